// File: doc/BRIEF.md
# Coprocessor Instruction Snoop Sequencer

This block sits next to a host CPU on a shared memory bus. It watches the words that the CPU fetches as instructions. It recognises a coprocessor opcode in the upper six bits of such a word, and it captures the low twelve bits as the coprocessor instruction. A coprocessor instruction is two words long. The CPU fetches the second word as if it were its next instruction, but that word is really the operand address. The block takes that word away from the CPU and gives the CPU a forged no-op word in its place. It then completes the read-restart and release handshake with the CPU.

With the address in hand, the sequencer can follow one level of indirection. It then becomes a bus master and reads one to three operand words from consecutive addresses. It strobes each word into the exponent, high-mantissa or low-mantissa register, depending on the operand format. Pending I/O memory requests always go first. The block ends with a one-cycle start pulse to the execution stage. From detection until that pulse it reports itself busy and keeps the CPU disabled.

Word bits are numbered from the most significant end. Word bit 0 is vector index 17, and word bit n is vector index 17-n.

Top module: `cop_fetch_seq`

## Requirements
- R1: When idle, a word with `snoop_vld_i` and `cpu_ifetch_i` both high and `mem_data_i[17:12]` equal to octal 71 pulses `ld_ir_o` in that cycle. From the next cycle `busy_o` and `cpu_dis_o` are high and `ir_o` equals `mem_data_i[11:0]`. Any other word, or any word seen outside an instruction fetch, leaves the block idle.
- R2: While the block waits for the second word, `rdrst_block_o` is high. The next `snoop_vld_i` word is taken as the address word: `ld_ar_o` and `mem_dack_o` pulse in that cycle, and one cycle later `ar_o` equals `mem_data_i[16:0]`.
- R3: In the cycle after the address is captured, `cpu_rdrst_o` pulses for exactly one cycle, `rdrst_block_o` is low, and `bus_drive_o` is high with `bus_data_o` = octal 710000. The drive holds until `cpu_rel_i`, and `cpu_ack_o` pulses in the cycle where `cpu_rel_i` is seen.
- R4: If index 17 of the address word is 1, the block makes one extra read at `ar_o`. Bits [16:0] of the returned word are loaded into the address register with an `ld_ar_o` pulse and no operand strobe.
- R5: If instruction bit 10 (index 7 of the first word) is 1, the block makes no memory request and no indirection. `start_o` pulses right after the CPU release.
- R6: The format is first-word bits [1:0]. The operand strobes come in this order: 00 gives mantissa-high; 01 gives mantissa-high then mantissa-low; 10 gives exponent then mantissa-high; 11 gives exponent, mantissa-high, mantissa-low. At most one load strobe is high in any cycle.
- R7: Each operand read uses `mem_addr_o` = `ar_o`, and `ar_o` increments by one after each operand word.
- R8: `mem_req_o` is never high while `io_pend_i` is high.
- R9: `start_o` is a one-cycle pulse in the cycle after the last operand word. `busy_o` and `cpu_dis_o` stay high until that pulse and fall in the following cycle.
- R10: `mem_req_o` stays up until `mem_aack_i`. The read word is taken on `mem_rvld_i`, and `mem_dack_o` pulses in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_data_i | input | 18 | Memory data lines |
| snoop_vld_i | input | 1 | A word is on the bus for the CPU |
| cpu_ifetch_i | input | 1 | The CPU is in an instruction fetch |
| cpu_rel_i | input | 1 | CPU releases after the forged response |
| io_pend_i | input | 1 | An I/O memory request is pending |
| mem_aack_i | input | 1 | Memory address acknowledge |
| mem_rvld_i | input | 1 | Memory read-restart with data |
| mem_req_o | output | 1 | Own memory request |
| mem_addr_o | output | 17 | Address of the own request |
| mem_dack_o | output | 1 | Data acknowledge to memory |
| rdrst_block_o | output | 1 | Blocks the CPU read-restart strobe |
| cpu_rdrst_o | output | 1 | Read-restart pulse sent to the CPU |
| cpu_ack_o | output | 1 | Acknowledge of the CPU release |
| cpu_dis_o | output | 1 | Suppresses further CPU memory activity |
| bus_drive_o | output | 1 | Block drives the data lines |
| bus_data_o | output | 18 | Forged no-op word |
| ld_ir_o | output | 1 | Instruction register load strobe |
| ld_ar_o | output | 1 | Address register load strobe |
| ld_exp_o | output | 1 | Exponent register load strobe |
| ld_mhi_o | output | 1 | High mantissa load strobe |
| ld_mlo_o | output | 1 | Low mantissa load strobe |
| ir_o | output | 12 | Captured instruction bits |
| ar_o | output | 17 | Address register |
| busy_o | output | 1 | Sequence in progress |
| start_o | output | 1 | Start pulse to execution |

## Verification
A wrong state register in this block shows up within one cycle at the ports. A misplaced state gives a missing or extra strobe on the handshake lines, a request raised during pending I/O, or a forged word appearing at the wrong time. A wrong operand-kind register shows up as the wrong load strobe, or as a wrong count of reads, on the very next data word. A wrong address register shows up on `mem_addr_o` at the next request, and on `ar_o` in the cycle after each word.

// File: rtl/cop_pkg.sv
package cop_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_IND, K_EXP, K_MHI, K_MLO
  } opk_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_FORGE, S_REL, S_REQ, S_DAT, S_START
  } st_t;

  // fmt[1]: exponent word present, fmt[0]: low mantissa word present
  function automatic opk_t first_op(input logic [1:0] fmt);
    return fmt[1] ? K_EXP : K_MHI;
  endfunction

  function automatic opk_t after_op(input logic [1:0] fmt, input opk_t cur);
    case (cur)
      K_IND:   return first_op(fmt);
      K_EXP:   return K_MHI;
      K_MHI:   return fmt[0] ? K_MLO : K_NONE;
      default: return K_NONE;
    endcase
  endfunction

  function automatic opk_t launch_op(input logic nomem, input logic ind,
                                     input logic [1:0] fmt);
    if (nomem) return K_NONE;
    if (ind) return K_IND;
    return first_op(fmt);
  endfunction

endpackage

// File: rtl/cop_opdet.sv
module cop_opdet #(
  parameter int WORD_W = 18,
  parameter int OPC_W  = 6,
  parameter logic [OPC_W-1:0] OPCODE = 6'o71
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              vld_i,
  input  logic              ifetch_i,
  output logic              hit_o
);
  assign hit_o = vld_i && ifetch_i && (word_i[WORD_W-1 -: OPC_W] == OPCODE);
endmodule

// File: rtl/cop_areg.sv
module cop_areg #(
  parameter int AR_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            inc_i,
  input  logic [AR_W-1:0] din_i,
  output logic [AR_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= din_i;
    else if (inc_i)  q_o <= q_o + 1'b1;
  end

  AST_AR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i) |=> (q_o == AR_W'($past(q_o) + 1'b1))); // R7
endmodule

// File: rtl/cop_fetch_seq.sv
module cop_fetch_seq #(
  parameter int WORD_W = 18,
  parameter int OPC_W  = 6,
  parameter logic [OPC_W-1:0]  OPCODE   = 6'o71,
  parameter logic [WORD_W-1:0] NOP_WORD = 18'o710000,
  parameter int NOMEM_BITNUM = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mem_data_i,
  input  logic              snoop_vld_i,
  input  logic              cpu_ifetch_i,
  input  logic              cpu_rel_i,
  input  logic              io_pend_i,
  input  logic              mem_aack_i,
  input  logic              mem_rvld_i,
  output logic              mem_req_o,
  output logic [WORD_W-2:0] mem_addr_o,
  output logic              mem_dack_o,
  output logic              rdrst_block_o,
  output logic              cpu_rdrst_o,
  output logic              cpu_ack_o,
  output logic              cpu_dis_o,
  output logic              bus_drive_o,
  output logic [WORD_W-1:0] bus_data_o,
  output logic              ld_ir_o,
  output logic              ld_ar_o,
  output logic              ld_exp_o,
  output logic              ld_mhi_o,
  output logic              ld_mlo_o,
  output logic [WORD_W-OPC_W-1:0] ir_o,
  output logic [WORD_W-2:0] ar_o,
  output logic              busy_o,
  output logic              start_o
);
  import cop_pkg::*;

  localparam int IR_W      = WORD_W - OPC_W;
  localparam int AR_W      = WORD_W - 1;
  localparam int IND_IDX   = WORD_W - 1;
  localparam int NOMEM_IDX = WORD_W - 1 - NOMEM_BITNUM;

  st_t  st_q;
  opk_t kind_q;
  logic [IR_W-1:0] ir_q;
  logic ind_q;

  // named internal events
  logic det_hit, cap_addr, dat_done, ind_done, op_word, rel_seen;
  logic nomem;
  logic [1:0] fmt;

  cop_opdet #(.WORD_W(WORD_W), .OPC_W(OPC_W), .OPCODE(OPCODE)) u_det (
    .word_i(mem_data_i), .vld_i(snoop_vld_i), .ifetch_i(cpu_ifetch_i),
    .hit_o(det_hit)
  );

  assign nomem    = ir_q[NOMEM_IDX];
  assign fmt      = ir_q[1:0];
  assign cap_addr = (st_q == S_ADDR) && snoop_vld_i;
  assign dat_done = (st_q == S_DAT) && mem_rvld_i;
  assign ind_done = dat_done && (kind_q == K_IND);
  assign op_word  = dat_done && (kind_q != K_IND);
  assign rel_seen = (st_q == S_REL) && cpu_rel_i;

  cop_areg #(.AR_W(AR_W)) u_ar (
    .clk(clk), .rst_n(rst_n),
    .load_i(cap_addr || ind_done),
    .inc_i(op_word),
    .din_i(mem_data_i[AR_W-1:0]),
    .q_o(ar_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_NONE;
      ir_q   <= '0;
      ind_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE:  if (det_hit) begin
                   ir_q <= mem_data_i[IR_W-1:0];
                   st_q <= S_ADDR;
                 end
        S_ADDR:  if (cap_addr) begin
                   ind_q <= mem_data_i[IND_IDX];
                   st_q  <= S_FORGE;
                 end
        S_FORGE: st_q <= S_REL;
        S_REL:   if (rel_seen) begin
                   kind_q <= launch_op(nomem, ind_q, fmt);
                   st_q   <= (launch_op(nomem, ind_q, fmt) == K_NONE) ? S_START : S_REQ;
                 end
        S_REQ:   if (mem_req_o && mem_aack_i) st_q <= S_DAT;
        S_DAT:   if (dat_done) begin
                   kind_q <= after_op(fmt, kind_q);
                   st_q   <= (after_op(fmt, kind_q) == K_NONE) ? S_START : S_REQ;
                 end
        S_START: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ld_ir_o       = (st_q == S_IDLE) && det_hit;
  assign ld_ar_o       = cap_addr || ind_done;
  assign mem_dack_o    = cap_addr || dat_done;
  assign rdrst_block_o = (st_q == S_ADDR);
  assign cpu_rdrst_o   = (st_q == S_FORGE);
  assign bus_drive_o   = (st_q == S_FORGE) || (st_q == S_REL);
  assign bus_data_o    = bus_drive_o ? NOP_WORD : '0;
  assign cpu_ack_o     = rel_seen;
  assign mem_req_o     = (st_q == S_REQ) && !io_pend_i;
  assign mem_addr_o    = ar_o;
  assign ld_exp_o      = op_word && (kind_q == K_EXP);
  assign ld_mhi_o      = op_word && (kind_q == K_MHI);
  assign ld_mlo_o      = op_word && (kind_q == K_MLO);
  assign ir_o          = ir_q;
  assign busy_o        = (st_q != S_IDLE);
  assign cpu_dis_o     = busy_o;
  assign start_o       = (st_q == S_START);

  AST_DETECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir_o |=> (busy_o && cpu_dis_o)); // R1
  AST_CAPTURE_THEN_FORGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_addr |=> (cpu_rdrst_o && !rdrst_block_o)); // R2
  AST_FORGED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdrst_o |-> (bus_drive_o && bus_data_o == NOP_WORD)); // R3
  AST_RDRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdrst_o |=> !cpu_rdrst_o); // R3
  AST_NOMEM_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && nomem) |-> !mem_req_o); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_ir_o, ld_ar_o, ld_exp_o, ld_mhi_o, ld_mlo_o})); // R6
  AST_IO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    io_pend_i |-> !mem_req_o); // R8
  AST_START_END: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (!start_o && !busy_o)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_aack_i) |=> (mem_req_o || io_pend_i)); // R10
endmodule

// File: tb/cop_fetch_seq_tb.sv
`timescale 1ns/100ps
module cop_fetch_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] mdata = '0;
  logic snoop_vld = 0, ifetch = 0, cpu_rel = 0, io_pend = 0, aack = 0, rvld = 0;
  logic mem_req_o, mem_dack_o, rdrst_block_o, cpu_rdrst_o, cpu_ack_o, cpu_dis_o;
  logic bus_drive_o, ld_ir_o, ld_ar_o, ld_exp_o, ld_mhi_o, ld_mlo_o, busy_o, start_o;
  logic [16:0] mem_addr_o, ar_o;
  logic [17:0] bus_data_o;
  logic [11:0] ir_o;

  int n_run = 0, n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cop_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_data_i(mdata), .snoop_vld_i(snoop_vld),
    .cpu_ifetch_i(ifetch), .cpu_rel_i(cpu_rel), .io_pend_i(io_pend),
    .mem_aack_i(aack), .mem_rvld_i(rvld), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_dack_o(mem_dack_o), .rdrst_block_o(rdrst_block_o),
    .cpu_rdrst_o(cpu_rdrst_o), .cpu_ack_o(cpu_ack_o), .cpu_dis_o(cpu_dis_o),
    .bus_drive_o(bus_drive_o), .bus_data_o(bus_data_o), .ld_ir_o(ld_ir_o),
    .ld_ar_o(ld_ar_o), .ld_exp_o(ld_exp_o), .ld_mhi_o(ld_mhi_o), .ld_mlo_o(ld_mlo_o),
    .ir_o(ir_o), .ar_o(ar_o), .busy_o(busy_o), .start_o(start_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // operand plan: 0 exponent, 1 high mantissa, 2 low mantissa
  function automatic int n_words(input logic [1:0] f);
    return 1 + int'(f[1]) + int'(f[0]);
  endfunction
  function automatic int kind_at(input logic [1:0] f, input int i);
    int seq [3];
    int k = 0;
    if (f[1]) begin seq[k] = 0; k++; end
    seq[k] = 1; k++;
    if (f[0]) begin seq[k] = 2; k++; end
    return seq[i];
  endfunction

  task automatic mem_txn(input logic [16:0] exp_addr, input logic [17:0] data,
                         input int kind, input int iodly);
    bit got = 0;
    if (iodly > 0) begin
      io_pend = 1;
      for (int j = 0; j < iodly; j++) begin
        @(negedge clk); #1;
        chk("R8 request while io pending", mem_req_o, 0);
      end
      io_pend = 0;
    end
    for (int w = 0; w < 20; w++) begin
      #0.5;
      if (mem_req_o) begin got = 1; break; end
      @(negedge clk);
    end
    chk("R10 request raised", got, 1);
    chk("R7 request address", mem_addr_o, exp_addr);
    aack = 1;
    @(negedge clk); aack = 0; #1;
    chk("R10 request dropped after ack", mem_req_o, 0);
    rvld = 1; mdata = data; #0.5;
    chk("R10 data ack", mem_dack_o, 1);
    chk("R4 indirect load", ld_ar_o, kind == 3);
    chk("R6 exponent strobe", ld_exp_o, kind == 0);
    chk("R6 high strobe", ld_mhi_o, kind == 1);
    chk("R6 low strobe", ld_mlo_o, kind == 2);
    @(negedge clk); rvld = 0; #0.5;
  endtask

  task automatic run_instr(input logic [1:0] fmt, input bit nomem, input bit ind,
                           input logic [16:0] addr, input logic [16:0] tgt, input int iodly);
    logic [17:0] w1, w2;
    logic [16:0] cur;
    w1 = {6'o71, 12'h0};
    w1[1:0] = fmt;
    w1[7] = nomem;
    w1[11:8] = 4'($urandom_range(0, 15));
    w2 = {ind, addr};
    @(negedge clk);
    mdata = w1; snoop_vld = 1; ifetch = 1; #0.5;
    chk("R1 ir load strobe", ld_ir_o, 1);
    @(negedge clk); snoop_vld = 0; ifetch = 0; #0.5;
    chk("R1 busy", busy_o, 1);
    chk("R1 cpu disable", cpu_dis_o, 1);
    chk("R1 ir value", ir_o, w1[11:0]);
    chk("R2 restart blocked", rdrst_block_o, 1);
    mdata = w2; snoop_vld = 1; #0.5;
    chk("R2 address load", ld_ar_o, 1);
    chk("R2 data ack", mem_dack_o, 1);
    @(negedge clk); snoop_vld = 0; #0.5;
    chk("R2 address value", ar_o, addr);
    chk("R3 restart pulse", cpu_rdrst_o, 1);
    chk("R3 block released", rdrst_block_o, 0);
    chk("R3 bus driven", bus_drive_o, 1);
    chk("R3 forged word", bus_data_o, 18'o710000);
    @(negedge clk); #0.5;
    chk("R3 restart one cycle", cpu_rdrst_o, 0);
    chk("R3 drive held", bus_drive_o, 1);
    cpu_rel = 1; #0.5;
    chk("R3 release ack", cpu_ack_o, 1);
    @(negedge clk); cpu_rel = 0; #0.5;
    cur = addr;
    if (nomem) begin
      chk("R5 no request", mem_req_o, 0);
    end else begin
      if (ind) begin
        mem_txn(cur, {1'b0, tgt}, 3, iodly);
        chk("R4 effective address", ar_o, tgt);
        cur = tgt;
      end
      for (int i = 0; i < n_words(fmt); i++) begin
        mem_txn(cur, 18'($urandom), kind_at(fmt, i), (i == 0 && !ind) ? iodly : 0);
        cur = cur + 1'b1;
        chk("R7 address step", ar_o, cur);
      end
    end
    chk("R9 start pulse", start_o, 1);
    chk("R9 busy at start", busy_o, 1);
    @(negedge clk); #0.5;
    chk("R9 start ends", start_o, 0);
    chk("R9 busy ends", busy_o, 0);
    chk("R9 cpu disable ends", cpu_dis_o, 0);
  endtask

  task automatic ignore_word(input logic [17:0] w, input bit f);
    @(negedge clk);
    mdata = w; snoop_vld = 1; ifetch = f; #0.5;
    chk("R1 no strobe on other word", ld_ir_o, 0);
    @(negedge clk); snoop_vld = 0; ifetch = 0; #0.5;
    chk("R1 stays idle", busy_o, 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #0.5;
    chk("R1 reset busy", busy_o, 0);
    chk("R9 reset start", start_o, 0);
    chk("R10 reset request", mem_req_o, 0);
    chk("R3 reset drive", bus_drive_o, 0);
    rst_n = 1;
    // directed corners
    ignore_word(18'o700000, 1);
    ignore_word(18'o710000, 0);
    run_instr(2'b11, 0, 0, 17'h00100, 17'h0, 0);
    run_instr(2'b00, 0, 0, 17'h1FFFF, 17'h0, 0);
    run_instr(2'b10, 0, 1, 17'h00200, 17'h03000, 3);
    run_instr(2'b01, 0, 0, 17'h00300, 17'h0, 2);
    run_instr(2'b11, 1, 1, 17'h00400, 17'h05000, 0);
    // random mix
    for (int t = 0; t < 40; t++) begin
      run_instr(2'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0),
                $urandom_range(0, 1) == 1, 17'($urandom), 17'($urandom),
                $urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) ignore_word(18'($urandom), 1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule